// File: doc/BRIEF.md
# Per-Bit Access-Policy Control/Status Register

This block is one 32-bit control/status word in which each bit follows its own access policy. A parameter vector gives every bit a 4-bit attribute code, and a second parameter marks which bits survive a warm reset. The policies cover hardware status that the bus cannot change, plain storage, event flags cleared by writing 1, flags set by reading, fields frozen by a lock, commands that hardware clears, fields written once, and write-only strobes.

Software reaches the word through a strobe-based slave port: `wr_en` with `wr_data` writes all 32 bits in one cycle, and `rd_en` marks a read whose data appears combinationally on `rd_data`. Hardware logic next to the register drives per-bit event-set pulses, self-clear pulses and live status values, and a single lock input. Cold reset is asynchronous and active-low. Warm reset is synchronous and active-low.

Top module: `access_policy_reg`

## Requirements
- R1: Attribute codes are RO=0, RW=1, W1C=2, RSET=3, RWL=4, RWSC=5, RWSCL=6, WONCE=7, WONLY=8. The default map gives bit i the code (i mod 9). Bits 31:16 are sticky and bits 15:0 are not. The reset value is 32'h5A5A_C3C3. An RO bit reads `sts_in[i]`, and bus writes to it have no effect.
- R2: An RW bit takes `wr_data[i]` at the edge that ends a `wr_en` cycle and reads back its stored value.
- R3: A W1C bit becomes 1 the cycle after `set_in[i]`. A write with data 1 clears it and a write with data 0 leaves it unchanged. If a set and a clearing write arrive in the same cycle, the bit ends at 1.
- R4: An RSET bit becomes 1 in the cycle after an `rd_en` cycle. A write of 1 clears it and a write of 0 has no effect. If a read and a clearing write arrive in the same cycle, the bit ends at 1.
- R5: An RWL bit behaves like RW while `lock` is 0 and ignores writes while `lock` is 1.
- R6: An RWSC bit behaves like RW, and `clr_in[i]` returns it to 0 in the next cycle. When a write and a clear arrive in the same cycle, the written value is kept.
- R7: An RWSCL bit behaves like RWSC, but writes are ignored while `lock` is 1. The clear input still acts while `lock` is 1.
- R8: A WONCE bit accepts only the first write after a reset. Later writes are ignored until a cold reset, or a warm reset on a non-sticky bit, re-arms it.
- R9: A WONLY bit always reads 0. A write with data 1 drives `wo_pulse[i]` high for exactly the following cycle. `wo_pulse` is 0 on every bit that is not WONLY.
- R10: In a cycle with `warm_rst_n` low, non-sticky bits load their reset value at the next edge, sticky bits hold their value and ignore bus and hardware inputs, and every `wo_pulse` bit goes to 0.
- R11: `cold_rst_n` low puts every bit at its reset value at once, re-arms all WONCE bits, clears `wo_pulse`, and takes priority over warm reset.
- R12: `rd_data` is combinational, so in an `rd_en` cycle it shows the value from before any read side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset that clears everything |
| warm_rst_n | input | 1 | Synchronous active-low warm reset that spares sticky bits |
| wr_en | input | 1 | Single-cycle bus write strobe |
| rd_en | input | 1 | Single-cycle bus read strobe |
| wr_data | input | 32 | Bus write data |
| rd_data | output | 32 | Read view of the word |
| lock | input | 1 | Freezes the lockable bits while high |
| set_in | input | 32 | Per-bit hardware event-set pulses |
| clr_in | input | 32 | Per-bit hardware self-clear pulses |
| sts_in | input | 32 | Per-bit live status for read-only bits |
| wo_pulse | output | 32 | Per-bit one-cycle write-effect pulses |

## Verification
The bench builds the block with its default parameters. Bit i takes code (i mod 9), so all nine policies appear both as a non-sticky bit in the lower half and as a sticky bit in the upper half. This puts every combination of policy and warm-reset domain within reach of one near-exhaustive pseudo-random sweep. The sweep runs for 20,000 cycles and includes rare warm resets, periodic cold resets, lock toggling and collisions of set, clear, read and write strobes in the same cycle. An arithmetic per-bit model predicts `rd_data` and `wo_pulse` every cycle.

// File: rtl/acc_attr_pkg.sv
package acc_attr_pkg;

  typedef enum logic [3:0] {
    AT_RO    = 4'd0,
    AT_RW    = 4'd1,
    AT_W1C   = 4'd2,
    AT_RSET  = 4'd3,
    AT_RWL   = 4'd4,
    AT_RWSC  = 4'd5,
    AT_RWSCL = 4'd6,
    AT_WONCE = 4'd7,
    AT_WONLY = 4'd8
  } acc_attr_e;

  localparam int ATTR_BITS = 4;
  localparam int DEF_W     = 32;

  // bit i gets code (i mod 9) so every policy appears in both halves
  function automatic logic [ATTR_BITS*DEF_W-1:0] default_map();
    logic [ATTR_BITS*DEF_W-1:0] m;
    m = '0;
    for (int i = 0; i < DEF_W; i++) begin
      m[ATTR_BITS*i +: ATTR_BITS] = ATTR_BITS'(i % 9);
    end
    return m;
  endfunction

endpackage

// File: rtl/acc_rst_dom.sv
module acc_rst_dom #(
  parameter int               WIDTH       = 32,
  parameter logic [WIDTH-1:0] STICKY_MASK = '0
) (
  input  logic             warm_rst_n,
  output logic [WIDTH-1:0] hold_o,
  output logic [WIDTH-1:0] clear_o
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_dom
      if (STICKY_MASK[gi]) begin : g_sticky
        assign hold_o[gi]  = ~warm_rst_n;
        assign clear_o[gi] = 1'b0;
      end else begin : g_plain
        assign hold_o[gi]  = 1'b0;
        assign clear_o[gi] = ~warm_rst_n;
      end
    end
  endgenerate

endmodule

// File: rtl/acc_bit.sv
module acc_bit
  import acc_attr_pkg::*;
#(
  parameter acc_attr_e ATTR = AT_RW,
  parameter bit        RST  = 1'b0
) (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic hold_i,
  input  logic clear_i,
  input  logic warm_any_i,
  input  logic wr_i,
  input  logic rd_i,
  input  logic wd_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic sts_i,
  input  logic lock_i,
  output logic rd_o,
  output logic pulse_o
);

  logic q_r, q_nx;
  logic done_r, done_nx;
  logic pulse_r, pulse_nx;
  logic upd_en;

  assign upd_en = ~hold_i;

  always_comb begin
    q_nx     = q_r;
    done_nx  = done_r;
    pulse_nx = 1'b0;
    if (clear_i) begin
      q_nx    = RST;
      done_nx = 1'b0;
    end else begin
      unique case (ATTR)
        AT_RO: ;
        AT_RW: begin
          if (wr_i) q_nx = wd_i;
        end
        AT_W1C: begin
          if (set_i)            q_nx = 1'b1;
          else if (wr_i && wd_i) q_nx = 1'b0;
        end
        AT_RSET: begin
          if (rd_i)             q_nx = 1'b1;
          else if (wr_i && wd_i) q_nx = 1'b0;
        end
        AT_RWL: begin
          if (wr_i && !lock_i) q_nx = wd_i;
        end
        AT_RWSC: begin
          if (wr_i)       q_nx = wd_i;
          else if (clr_i) q_nx = 1'b0;
        end
        AT_RWSCL: begin
          if (wr_i && !lock_i) q_nx = wd_i;
          else if (clr_i)      q_nx = 1'b0;
        end
        AT_WONCE: begin
          if (wr_i && !done_r) begin
            q_nx    = wd_i;
            done_nx = 1'b1;
          end
        end
        AT_WONLY: begin
          pulse_nx = wr_i & wd_i & ~warm_any_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      q_r    <= RST;
      done_r <= 1'b0;
    end else if (upd_en) begin
      q_r    <= q_nx;
      done_r <= done_nx;
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      pulse_r <= 1'b0;
    end else begin
      pulse_r <= pulse_nx;
    end
  end

  always_comb begin
    unique case (ATTR)
      AT_RO:    rd_o = sts_i;
      AT_WONLY: rd_o = 1'b0;
      default:  rd_o = q_r;
    endcase
  end

  assign pulse_o = pulse_r;

endmodule

// File: rtl/access_policy_reg.sv
module access_policy_reg
  import acc_attr_pkg::*;
#(
  parameter int                         WIDTH       = 32,
  parameter logic [ATTR_BITS*WIDTH-1:0] ATTR_VEC    = default_map(),
  parameter logic [WIDTH-1:0]           STICKY_MASK = 32'hFFFF_0000,
  parameter logic [WIDTH-1:0]           RST_VAL     = 32'h5A5A_C3C3
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             warm_rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             lock,
  input  logic [WIDTH-1:0] set_in,
  input  logic [WIDTH-1:0] clr_in,
  input  logic [WIDTH-1:0] sts_in,
  output logic [WIDTH-1:0] wo_pulse
);

  logic [WIDTH-1:0] hold_v;
  logic [WIDTH-1:0] clear_v;
  logic             warm_any;

  assign warm_any = ~warm_rst_n;

  acc_rst_dom #(
    .WIDTH       (WIDTH),
    .STICKY_MASK (STICKY_MASK)
  ) u_dom (
    .warm_rst_n (warm_rst_n),
    .hold_o     (hold_v),
    .clear_o    (clear_v)
  );

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      acc_bit #(
        .ATTR (acc_attr_e'(ATTR_VEC[ATTR_BITS*gi +: ATTR_BITS])),
        .RST  (RST_VAL[gi])
      ) u_bit (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .hold_i     (hold_v[gi]),
        .clear_i    (clear_v[gi]),
        .warm_any_i (warm_any),
        .wr_i       (wr_en),
        .rd_i       (rd_en),
        .wd_i       (wr_data[gi]),
        .set_i      (set_in[gi]),
        .clr_i      (clr_in[gi]),
        .sts_i      (sts_in[gi]),
        .lock_i     (lock),
        .rd_o       (rd_data[gi]),
        .pulse_o    (wo_pulse[gi])
      );
    end
  endgenerate

endmodule

// File: rtl/acc_reg_chk.sv
module acc_reg_chk
  import acc_attr_pkg::*;
#(
  parameter int                         WIDTH       = 32,
  parameter logic [ATTR_BITS*WIDTH-1:0] ATTR_VEC    = default_map(),
  parameter logic [WIDTH-1:0]           STICKY_MASK = 32'hFFFF_0000
) (
  input logic             clk,
  input logic             cold_rst_n,
  input logic             warm_rst_n,
  input logic             rd_en,
  input logic             lock,
  input logic [WIDTH-1:0] set_in,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] wo_pulse
);

  logic [WIDTH-1:0] m_w1c, m_rs, m_rwl, m_wo, m_keep;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_m
      localparam acc_attr_e A = acc_attr_e'(ATTR_VEC[ATTR_BITS*gi +: ATTR_BITS]);
      assign m_w1c[gi]  = (A == AT_W1C);
      assign m_rs[gi]   = (A == AT_RSET);
      assign m_rwl[gi]  = (A == AT_RWL);
      assign m_wo[gi]   = (A == AT_WONLY);
      assign m_keep[gi] = STICKY_MASK[gi] && (A != AT_RO) && (A != AT_WONLY);
    end
  endgenerate

  p_w1c_set_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst_n |=> ((rd_data & $past(set_in & m_w1c)) == $past(set_in & m_w1c)));

  p_rs_read_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst_n && rd_en) |=> ((rd_data & m_rs) == m_rs));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst_n && lock) |=> ((rd_data & m_rwl) == $past(rd_data & m_rwl)));

  p_wo_reads_zero_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((rd_data & m_wo) == '0));

  p_pulse_mask_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((wo_pulse & ~m_wo) == '0));

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> ((rd_data & m_keep) == $past(rd_data & m_keep)));

endmodule

bind access_policy_reg acc_reg_chk #(
  .WIDTH       (WIDTH),
  .ATTR_VEC    (ATTR_VEC),
  .STICKY_MASK (STICKY_MASK)
) u_chk (
  .clk        (clk),
  .cold_rst_n (cold_rst_n),
  .warm_rst_n (warm_rst_n),
  .rd_en      (rd_en),
  .lock       (lock),
  .set_in     (set_in),
  .rd_data    (rd_data),
  .wo_pulse   (wo_pulse)
);

// File: tb/tb_access_policy_reg.sv
`timescale 1ns/1ps
module tb_access_policy_reg;

  localparam int W     = 32;
  localparam int NCYC  = 20000;
  localparam logic [W-1:0] RSTV = 32'h5A5A_C3C3;

  logic         clk = 1'b0;
  logic         cold_rst_n, warm_rst_n, wr_en, rd_en, lock;
  logic [W-1:0] wr_data, rd_data, set_in, clr_in, sts_in, wo_pulse;

  int nvec = 0;
  int nerr = 0;

  logic [W-1:0] mq, md, mp, nq, nd, np;
  logic [31:0]  rs = 32'h1357_9BDF;

  always #4 clk = ~clk;

  access_policy_reg dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .lock(lock), .set_in(set_in), .clr_in(clr_in), .sts_in(sts_in),
    .wo_pulse(wo_pulse)
  );

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R1";  1: return "R2";  2: return "R3";
      3: return "R4";  4: return "R5";  5: return "R6";
      6: return "R7";  7: return "R8";  default: return "R9";
    endcase
  endfunction

  // expected read view, R1 encodings: code = i mod 9, RO=0, WONLY=8
  function automatic logic [W-1:0] view();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) begin
      if (i % 9 == 0)      v[i] = sts_in[i];
      else if (i % 9 == 8) v[i] = 1'b0;
      else                 v[i] = mq[i];
    end
    return v;
  endfunction

  task automatic compare(input string ovr);
    logic [W-1:0] ev;
    ev = view();
    nvec++;
    if (rd_data !== ev) begin
      for (int i = 0; i < W; i++) begin
        if (rd_data[i] !== ev[i]) begin
          nerr++;
          $display("FAIL %s rd_data bit %0d: actual %b expected %b",
                   (ovr != "") ? ovr : tag_of(i % 9), i, rd_data[i], ev[i]);
          break;
        end
      end
    end
    nvec++;
    if (wo_pulse !== mp) begin
      nerr++;
      $display("FAIL %s wo_pulse: actual %h expected %h",
               (ovr != "") ? ovr : "R9", wo_pulse, mp);
    end
  endtask

  // next state from the requirements, using the inputs now applied
  task automatic predict();
    for (int i = 0; i < W; i++) begin
      int a;
      bit s;
      a = i % 9;
      s = (i >= 16);
      nq[i] = mq[i]; nd[i] = md[i]; np[i] = 1'b0;
      if (!warm_rst_n) begin
        if (!s) begin nq[i] = RSTV[i]; nd[i] = 1'b0; end
      end else begin
        case (a)
          1: if (wr_en) nq[i] = wr_data[i];
          2: if (set_in[i]) nq[i] = 1'b1; else if (wr_en && wr_data[i]) nq[i] = 1'b0;
          3: if (rd_en) nq[i] = 1'b1; else if (wr_en && wr_data[i]) nq[i] = 1'b0;
          4: if (wr_en && !lock) nq[i] = wr_data[i];
          5: if (wr_en) nq[i] = wr_data[i]; else if (clr_in[i]) nq[i] = 1'b0;
          6: if (wr_en && !lock) nq[i] = wr_data[i]; else if (clr_in[i]) nq[i] = 1'b0;
          7: if (wr_en && !md[i]) begin nq[i] = wr_data[i]; nd[i] = 1'b1; end
          8: np[i] = wr_en & wr_data[i];
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    string ovr;
    bool_init();
    mq = RSTV; md = '0; mp = '0;
    repeat (3) @(negedge clk);
    #1 compare("R11");              // reset state while cold reset held
    nq = RSTV; nd = '0; np = '0;
    ovr = "R11";
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      mq = nq; md = nd; mp = np;
      rs = rnd(rs); wr_data = rs;
      rs = rnd(rs); sts_in  = rs;
      rs = rnd(rs); set_in  = rs & rnd(rs);
      rs = rnd(rs); clr_in  = rs & rnd(rs);
      rs = rnd(rs);
      wr_en      = (rs[1:0] == 2'b00);
      rd_en      = (rs[3:2] == 2'b00);
      warm_rst_n = (rs[8:4] != 5'd0);
      if (rs[15:9] == 7'd0) lock = ~lock;
      cold_rst_n = !((c % 1500) == 700);
      if (!cold_rst_n) begin
        mq = RSTV; md = '0; mp = '0;
        ovr = "R11";
      end else if (ovr == "" && rd_en) begin
        ovr = "";                   // R12: pre-read value checked below
      end
      #1;
      if (ovr == "" && rd_en) compare("");  // R4 R12 pre-side-effect view
      else compare(ovr);
      if (!cold_rst_n) begin
        nq = RSTV; nd = '0; np = '0;
      end else begin
        predict();
      end
      ovr = (!cold_rst_n) ? "R11" : (!warm_rst_n ? "R10" : "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  task automatic bool_init();
    cold_rst_n = 1'b0; warm_rst_n = 1'b1;
    wr_en = 1'b0; rd_en = 1'b0; lock = 1'b0;
    wr_data = '0; set_in = '0; clr_in = '0; sts_in = '0;
  endtask

endmodule